// File: doc/BRIEF.md
# OR-Branch Microprogram Sequencer

This block steps through a microprogram without a microprogram counter. Each microword names its own successor in a next-address field. A branch-select field in the same word picks which condition flags, if any, are ORed into that field. Setting one flag gives a two-way branch. Setting several flags at once gives a multi-way branch whose targets differ only in the ORed bit positions.

One microword is the main dispatch. Its successor comes from an instruction-decode lookup indexed by the instruction register. Most decode entries name a group of eight microwords, and the destination addressing mode supplies the low three address bits. The microprogram is a small demonstration table held inside the block.

The microaddress is a 9-bit register that updates once per clock. The control word is decoded from the current microaddress, so it changes in the same cycle as the address. A stall input freezes the sequencer while a bus cycle is pending.

Top module: `useq_top`

## Requirements
Addresses are written in octal. Condition flags are encoded as cond[3]=N, cond[2]=Z, cond[1]=V, cond[0]=C. The control word is {ld_ir, inc_pc, op[5:0]}.

- R1: A clock edge with `rst` high sets `uaddr` to the power-on entry 000. `rst` overrides `stall`.
- R2: There is no counter. A word without a branch moves to its own next-address field: 000 goes to 016, and every word not listed in R3 to R8 goes to 016.
- R3: Word 016 is the fetch step. It drives ld_ir=1 and always continues to 015.
- R4: Word 015 is the dispatch step. It drives inc_pc=1. Its successor is chosen by ir[15:12] as follows:
  - 0 goes to 003
  - 1 goes to 040
  - 2 goes to 060
  - 3 goes to 160
  - 4 goes to 220
  - 5 goes to 260
  - 6 goes to 400
  - any other value goes to 140
- R5: For the grouped dispatch entries (ir[15:12] = 1 to 4), the addressing mode ir[5:3] is placed in the low three bits of the target. The individual entries ignore the mode.
- R6: Word 260 is a zero test. It goes to 702 when Z=1 and to 700 when Z=0.
- R7: Word 400 is a carry test. It goes to 406 when C=1 and to 402 when C=0.
- R8: Word 220 is an eight-way branch from base 403. Z ORs in 004, N ORs in 020 and C ORs in 040.
- R9: With `stall` high and `rst` low, `uaddr` and `ctrl` keep their values across the edge.
- R10: op equals uaddr[5:0] in every word. ld_ir is 1 only at 016, and inc_pc is 1 only at 015.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the current microaddress |
| cond | input | 4 | Condition flags {N,Z,V,C} |
| ir | input | 16 | Instruction register |
| uaddr | output | 9 | Current microaddress |
| ctrl | output | 8 | Control word {ld_ir, inc_pc, op[5:0]} |

## Verification
The flags, the instruction register and stall that are present before a rising edge decide `uaddr` after that single edge; no other register lies between them. `ctrl` is decoded from `uaddr` with no register, so it is due in the same cycle as the new address. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares both outputs at the next falling edge against a model that advances one step per edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W   = 9;
    localparam int IR_W   = 16;
    localparam int COND_W = 4;
    localparam int OP_W   = 6;
    localparam int MODE_W = 3;
    localparam int MODE_LSB = 3;
    localparam int OPC_W  = 4;

    typedef logic [UA_W-1:0] uaddr_t;

    typedef enum logic [2:0] {
        BR_NONE,
        BR_ZERO,
        BR_CARRY,
        BR_NZC,
        BR_DISPATCH
    } br_sel_t;

    typedef struct packed {
        logic            ld_ir;
        logic            inc_pc;
        logic [OP_W-1:0] op;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        uaddr_t  nxt;
        br_sel_t sel;
        ctrl_t   ctrl;
    } uword_t;

    // flag positions inside cond
    localparam int CB_N = 3;
    localparam int CB_Z = 2;
    localparam int CB_V = 1;
    localparam int CB_C = 0;

    // fixed microaddresses
    localparam uaddr_t UA_ENTRY = 9'o000;
    localparam uaddr_t UA_FETCH = 9'o016;
    localparam uaddr_t UA_DISP  = 9'o015;
    localparam uaddr_t UA_ZTEST = 9'o260;
    localparam uaddr_t UA_CTEST = 9'o400;
    localparam uaddr_t UA_MWAY  = 9'o220;

    // OR positions for the single-flag tests
    localparam int ZBIT = 1;
    localparam int CBIT = 2;

    // lanes of the eight-way branch: flag index and address bit it sets
    localparam int NLANE = 3;
    localparam int MW_COND [NLANE] = '{CB_Z, CB_N, CB_C};
    localparam int MW_BIT  [NLANE] = '{2, 4, 5};

    function automatic uword_t ucode_word(uaddr_t a);
        uword_t w;
        w.nxt         = UA_FETCH;
        w.sel         = BR_NONE;
        w.ctrl.ld_ir  = 1'b0;
        w.ctrl.inc_pc = 1'b0;
        w.ctrl.op     = a[OP_W-1:0];
        case (a)
            UA_ENTRY: w.nxt = UA_FETCH;
            UA_FETCH: begin
                w.nxt        = UA_DISP;
                w.ctrl.ld_ir = 1'b1;
            end
            UA_DISP: begin
                w.sel         = BR_DISPATCH;
                w.ctrl.inc_pc = 1'b1;
            end
            UA_ZTEST: begin
                w.nxt = 9'o700;
                w.sel = BR_ZERO;
            end
            UA_CTEST: begin
                w.nxt = 9'o402;
                w.sel = BR_CARRY;
            end
            UA_MWAY: begin
                w.nxt = 9'o403;
                w.sel = BR_NZC;
            end
            default: ;
        endcase
        return w;
    endfunction

    function automatic uaddr_t decode_target(logic [OPC_W-1:0] opc, logic [MODE_W-1:0] mode);
        uaddr_t base;
        logic   grouped;
        grouped = 1'b1;
        case (opc)
            4'd0: begin base = 9'o003; grouped = 1'b0; end
            4'd1: base = 9'o040;
            4'd2: base = 9'o060;
            4'd3: base = 9'o160;
            4'd4: base = 9'o220;
            4'd5: begin base = 9'o260; grouped = 1'b0; end
            4'd6: begin base = 9'o400; grouped = 1'b0; end
            default: begin base = 9'o140; grouped = 1'b0; end
        endcase
        return grouped ? (base | uaddr_t'(mode)) : base;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_t addr_i,
    output uword_t word_o
);
    always_comb word_o = ucode_word(addr_i);

    always_comb begin
        // R10
        ctrl_excl_chk: assert (!(word_o.ctrl.ld_ir && word_o.ctrl.inc_pc));
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int IRW = IR_W
) (
    input  logic [IRW-1:0] ir_i,
    output uaddr_t         target_o
);
    localparam int OPC_LSB = IRW - OPC_W;

    logic [OPC_W-1:0]  opc;
    logic [MODE_W-1:0] mode;
    logic              unused_ir;

    assign opc       = ir_i[IRW-1:OPC_LSB];
    assign mode      = ir_i[MODE_LSB+MODE_W-1:MODE_LSB];
    assign unused_ir = ^{ir_i[OPC_LSB-1:MODE_LSB+MODE_W], ir_i[MODE_LSB-1:0]};

    always_comb target_o = decode_target(opc, mode);
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int CW = COND_W
) (
    input  uword_t        word_i,
    input  logic [CW-1:0] cond_i,
    input  uaddr_t        disp_i,
    output uaddr_t        next_o
);
    uaddr_t lane_or [NLANE];
    uaddr_t nzc_mask;
    uaddr_t or_mask;
    uaddr_t allowed;
    logic   unused_v;

    assign unused_v = cond_i[CB_V];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_or[g] = cond_i[MW_COND[g]] ? (uaddr_t'(1) << MW_BIT[g]) : '0;
    end

    always_comb begin
        nzc_mask = '0;
        for (int k = 0; k < NLANE; k++) nzc_mask |= lane_or[k];
    end

    always_comb begin
        or_mask = '0;
        allowed = '0;
        case (word_i.sel)
            BR_ZERO: begin
                or_mask = cond_i[CB_Z] ? (uaddr_t'(1) << ZBIT) : '0;
                allowed = uaddr_t'(1) << ZBIT;
            end
            BR_CARRY: begin
                or_mask = cond_i[CB_C] ? (uaddr_t'(1) << CBIT) : '0;
                allowed = uaddr_t'(1) << CBIT;
            end
            BR_NZC: begin
                or_mask = nzc_mask;
                allowed = 9'o064;
            end
            default: ;
        endcase
        next_o = (word_i.sel == BR_DISPATCH) ? disp_i : (word_i.nxt | or_mask);
    end

    always_comb begin
        if (word_i.sel != BR_DISPATCH) begin
            // R8
            or_only_chk: assert (((next_o | allowed) == (word_i.nxt | allowed)) &&
                                 ((next_o & word_i.nxt) == word_i.nxt));
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int IRW = IR_W,
    parameter int CW  = COND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [CW-1:0]     cond,
    input  logic [IRW-1:0]    ir,
    output logic [UA_W-1:0]   uaddr,
    output logic [CTRL_W-1:0] ctrl
);
    uaddr_t ua_q;
    uaddr_t ua_d;
    uaddr_t disp;
    uword_t word;

    useq_store u_store (
        .addr_i (ua_q),
        .word_o (word)
    );

    useq_decode #(.IRW(IRW)) u_decode (
        .ir_i     (ir),
        .target_o (disp)
    );

    useq_next #(.CW(CW)) u_next (
        .word_i (word),
        .cond_i (cond),
        .disp_i (disp),
        .next_o (ua_d)
    );

    always_ff @(posedge clk) begin
        if (rst)         ua_q <= UA_ENTRY;
        else if (!stall) ua_q <= ua_d;
    end

    assign uaddr = ua_q;
    assign ctrl  = word.ctrl;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(uaddr) && $stable(ctrl)));

    // R3
    fetch_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_FETCH && !stall) |=> (uaddr == UA_DISP));

    // R6
    zero_test_chk: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_ZTEST && !stall) |=>
        (uaddr == ($past(cond[CB_Z]) ? 9'o702 : 9'o700)));

    // R7
    carry_test_chk: assert property (@(posedge clk) disable iff (rst)
        (uaddr == UA_CTEST && !stall) |=>
        (uaddr == ($past(cond[CB_C]) ? 9'o406 : 9'o402)));

    // R10
    ctrl_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl[CTRL_W-1], ctrl[CTRL_W-2]}));
endmodule

// File: tb/useq_top_test.sv
module useq_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [3:0]  cond = '0;
    logic [15:0] ir = '0;
    logic [8:0]  uaddr;
    logic [7:0]  ctrl;

    int checks = 0;
    int errors = 0;
    logic [8:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_top uut (
        .clk(clk), .rst(rst), .stall(stall),
        .cond(cond), .ir(ir), .uaddr(uaddr), .ctrl(ctrl)
    );

    function automatic logic [8:0] exp_next(logic [8:0] a, logic [3:0] c, logic [15:0] i);
        logic [8:0] m;
        m = {6'd0, i[5:3]};
        case (a)
            9'o000: return 9'o016;
            9'o016: return 9'o015;
            9'o015: case (i[15:12])
                4'd0: return 9'o003;
                4'd1: return 9'o040 | m;
                4'd2: return 9'o060 | m;
                4'd3: return 9'o160 | m;
                4'd4: return 9'o220 | m;
                4'd5: return 9'o260;
                4'd6: return 9'o400;
                default: return 9'o140;
            endcase
            9'o260: return c[2] ? 9'o702 : 9'o700;
            9'o400: return c[0] ? 9'o406 : 9'o402;
            9'o220: return 9'o403 | (c[2] ? 9'o004 : 9'o0) |
                           (c[3] ? 9'o020 : 9'o0) | (c[0] ? 9'o040 : 9'o0);
            default: return 9'o016;
        endcase
    endfunction

    function automatic logic [7:0] exp_ctrl(logic [8:0] a);
        return {a == 9'o016, a == 9'o015, a[5:0]};
    endfunction

    task automatic check_out(input string tag);
        checks++;
        if (uaddr !== model || ctrl !== exp_ctrl(model)) begin
            errors++;
            $display("FAIL %s: uaddr=%o ctrl=%h, expected uaddr=%o ctrl=%h",
                     tag, uaddr, ctrl, model, exp_ctrl(model));
        end
    endtask

    // present inputs at a falling edge, pass one rising edge, compare
    task automatic step(input logic s, input logic [3:0] c, input logic [15:0] i,
                        input string tag);
        stall = s; cond = c; ir = i;
        if (!s) model = exp_next(model, c, i);
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic to_dispatch();
        for (int k = 0; k < 4 && model != 9'o015; k++) step(1'b0, 4'h0, 16'h0, "R2");
    endtask

    initial begin
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        model = 9'o000;
        check_out("R1");
        rst = 1'b0;

        // R2 entry then R3 fetch
        step(1'b0, 4'h0, 16'h0, "R2");
        step(1'b0, 4'h0, 16'h0, "R3");
        // R9 stall at dispatch
        step(1'b1, 4'hF, 16'h5000, "R9");
        step(1'b1, 4'h0, 16'h1000, "R9");
        // R4 individual target, then R6 both ways
        step(1'b0, 4'h0, 16'h5038, "R4");
        step(1'b0, 4'h4, 16'h0, "R6");
        to_dispatch();
        step(1'b0, 4'h0, 16'h5000, "R4");
        step(1'b0, 4'hB, 16'h0, "R6");
        // R5 all modes of a grouped entry
        for (int m = 0; m < 8; m++) begin
            to_dispatch();
            step(1'b0, 4'h0, 16'h1000 | 16'(m << 3), "R5");
        end
        // R7 both ways
        for (int cv = 0; cv < 2; cv++) begin
            to_dispatch();
            step(1'b0, 4'h0, 16'h6000, "R4");
            step(1'b0, cv[0] ? 4'h1 : 4'hE, 16'h0, "R7");
        end
        // R8 every flag combination
        for (int f = 0; f < 16; f++) begin
            to_dispatch();
            step(1'b0, 4'h0, 16'h4000, "R4");
            step(1'b0, 4'(f), 16'h0, "R8");
        end
        // R10 random walk
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) == 0, 4'($urandom), 16'($urandom), "R10");
        end
        // R1 reset overrides stall mid-run
        rst = 1'b1; stall = 1'b1;
        @(posedge clk); @(negedge clk);
        model = 9'o000;
        check_out("R1");
        rst = 1'b0; stall = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule